// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It handles one multiplier bit per clock. Each step looks at the current low bit of the multiplier together with the bit shifted out in the step before. From that pair it adds the multiplicand into the upper half of the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole accumulator right by one place, copying the sign bit in. Signed operands therefore need no correction at the end.

A client holds the operands steady and pulses `start_i` for one cycle while `busy_o` is low. The block captures both operands on that edge and raises `busy_o`. It runs exactly `WIDTH` steps. When it finishes, it drops `busy_o` and raises `done_o` for one cycle, with the final product on `product_o`. The product stays on the port until the next accepted start.

The upper part of the accumulator carries one guard bit beyond `WIDTH`. With this guard bit, the case where both operands are the most negative value still gives the correct result. The reset input is asynchronous and active low. Inside the block, reset is asserted at once and is released in step with the clock.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy_o` and `done_o` are 0 and `product_o` is 0. Asserting reset in the middle of a multiplication clears `busy_o` at once.
- R2: A `start_i` sampled high on a rising edge while `busy_o` is low captures `mcand_i` and `mplier_i`, and `busy_o` is 1 after that edge.
- R3: `done_o` is 1 after exactly the `WIDTH`-th rising edge that follows the accepting edge. `busy_o` falls on that same edge, and `done_o` is 1 for exactly one cycle.
- R4: When `done_o` is 1, `product_o` equals the signed product of the captured operands, as a `2*WIDTH`-bit two's-complement value. For `WIDTH`=4: 0010×0111 gives 00001110, and 0010×1101 gives 11111010.
- R5: Most-negative times most-negative gives +2^(2*WIDTH-2). For `WIDTH`=8, 0x80×0x80 gives 0x4000, and 0x80×0x7F gives 0xC080.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The running result and its latency are unchanged.
- R7: Once `done_o` has pulsed, `product_o` keeps its value until the next accepted start, whatever the operand inputs do.
- R8: Changes to `mcand_i` or `mplier_i` after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The assertions assume that `start_i` is a synchronous level sampled at rising edges, and that the operands are valid on the accepting edge. They make no assumption about operand values after that edge. The bench drives every input at falling edges and holds the operands through the accepting edge. It then changes them on purpose while the block is busy and while it is idle. It also sends extra start pulses during a run. This shows that the captured values, the step counter and the one-cycle completion pulse stay as they are.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit_i,
  input  logic      prev_bit_i,
  output booth_op_e op_o
);

  always_comb begin
    unique case ({cur_bit_i, prev_bit_i})
      2'b10:   op_o = BOOTH_SUB;
      2'b01:   op_o = BOOTH_ADD;
      default: op_o = BOOTH_HOLD;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int ACC_W = WIDTH + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_op_e        op_i,
  output logic [ACC_W-1:0] res_o
);

  logic [ACC_W-1:0] mcand_ext;

  assign mcand_ext = {mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    unique case (op_i)
      BOOTH_ADD: res_o = acc_i + mcand_ext;
      BOOTH_SUB: res_o = acc_i - mcand_ext;
      default:   res_o = acc_i;
    endcase
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             last;

  // next-state
  always_comb begin
    load_o = start_i && !busy_q;
    step_o = busy_q;
    last   = busy_q && (cnt_q == LAST_STEP);
    cnt_en = load_o || busy_q;
    cnt_d  = load_o ? '0 : cnt_q + 1'b1;
    busy_d = busy_q;
    if (load_o) begin
      busy_d = 1'b1;
    end else if (last) begin
      busy_d = 1'b0;
    end
    done_d = last;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);  // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);  // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST_STEP));  // R3
  AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST_STEP) |=> busy_q);  // R6

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int ACC_W  = WIDTH + 1,
  localparam int PROD_W = 2 * WIDTH,
  localparam int FULL_W = ACC_W + WIDTH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WIDTH-1:0]  mcand_i,
  input  logic [WIDTH-1:0]  mplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PROD_W-1:0] product_o
);

  logic              rst_int_n;
  logic              load;
  logic              step;
  logic              busy;
  logic              done;
  booth_op_e         op;
  logic [ACC_W-1:0]  hi_q, hi_d;
  logic [WIDTH-1:0]  lo_q, lo_d;
  logic              aux_q, aux_d;
  logic [WIDTH-1:0]  mcand_q;
  logic [ACC_W-1:0]  sum;
  logic [FULL_W-1:0] joined;
  logic [FULL_W-1:0] shifted;
  logic              acc_en;

  booth_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy),
    .done_o  (done)
  );

  booth_recode u_recode (
    .cur_bit_i  (lo_q[0]),
    .prev_bit_i (aux_q),
    .op_o       (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i   (hi_q),
    .mcand_i (mcand_q),
    .op_i    (op),
    .res_o   (sum)
  );

  // next-state: arithmetic right shift of {sum, lo, aux}
  always_comb begin
    joined  = {sum, lo_q, aux_q};
    shifted = {sum[ACC_W-1], joined[FULL_W-1:1]};
    acc_en  = load || step;
    if (load) begin
      hi_d  = '0;
      lo_d  = mplier_i;
      aux_d = 1'b0;
    end else begin
      hi_d  = shifted[FULL_W-1:WIDTH+1];
      lo_d  = shifted[WIDTH:1];
      aux_d = shifted[0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      aux_q <= 1'b0;
    end else if (acc_en) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      aux_q <= aux_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= mcand_i;
    end
  end

  assign busy_o    = busy;
  assign done_o    = done;
  assign product_o = {hi_q[WIDTH-1:0], lo_q};

  logic [ACC_W:0] wide_sum;
  assign wide_sum = (op == BOOTH_SUB)
                  ? {hi_q[ACC_W-1], hi_q} - {{2{mcand_q[WIDTH-1]}}, mcand_q}
                  : {hi_q[ACC_W-1], hi_q} + {{2{mcand_q[WIDTH-1]}}, mcand_q};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && op != BOOTH_HOLD) |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));  // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !load) |=> $stable(product_o));  // R7
  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> $stable(mcand_q));  // R8
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_int_n |-> (!busy_o && !done_o));  // R1

endmodule

// File: tb/test_booth_mul_seq.sv
module test_booth_mul_seq;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start8 = 1'b0;
  logic [W-1:0]   a8 = '0, b8 = '0;
  logic           busy8, done8;
  logic [2*W-1:0] p8;

  logic           start4 = 1'b0;
  logic [3:0]     a4 = '0, b4 = '0;
  logic           busy4, done4;
  logic [7:0]     p4;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) i_booth_mul_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start8), .mcand_i(a8), .mplier_i(b8),
    .busy_o(busy8), .done_o(done8), .product_o(p8));

  booth_mul_seq #(.WIDTH(4)) i_booth_mul_seq_w4 (
    .clk(clk), .rst_n(rst_n), .start_i(start4), .mcand_i(a4), .mplier_i(b4),
    .busy_o(busy4), .done_o(done4), .product_o(p4));

  // {mcand, mplier, expected product}
  localparam logic [31:0] VEC [12] = '{
    {8'h03, 8'h05, 16'h000F},
    {8'hFF, 8'hFF, 16'h0001},
    {8'h7F, 8'h7F, 16'h3F01},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC080},
    {8'h00, 8'h5A, 16'h0000},
    {8'h55, 8'hAA, 16'hE372},
    {8'h0C, 8'hF9, 16'hFFAC},
    {8'h9C, 8'h03, 16'hFED4},
    {8'h01, 8'h80, 16'hFF80},
    {8'h7F, 8'hFF, 16'hFF81},
    {8'hAA, 8'h55, 16'hE372}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns product and latency in rising edges after the accepting edge
  task automatic run8(input logic [W-1:0] a, input logic [W-1:0] b,
                      output logic [2*W-1:0] p, output int lat);
    @(negedge clk);
    a8 = a; b8 = b; start8 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start8 = 1'b0;
    lat = 0;
    while (!done8 && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    p = p8;
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, output logic [7:0] p);
    int lat;
    @(negedge clk);
    a4 = a; b4 = b; start4 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start4 = 1'b0;
    lat = 0;
    while (!done4 && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    p = p4;
  endtask

  initial begin
    logic [2*W-1:0] p;
    logic [7:0] q;
    int lat;

    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy8), 0);
    check("R1 done in reset", 32'(done8), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 busy after reset", 32'(busy8), 0);
    check("R1 done after reset", 32'(done8), 0);
    check("R1 product after reset", 32'(p8), 0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      run8(VEC[i][31:24], VEC[i][23:16], p, lat);
      check("R4 table product", 32'(p), 32'(VEC[i][15:0]));
      check("R3 latency", lat, W);
      check("R3 busy low at done", 32'(busy8), 0);
      @(negedge clk);
      check("R3 done one cycle", 32'(done8), 0);
    end

    // R5 explicit
    run8(8'h80, 8'h80, p, lat);
    check("R5 most negative squared", 32'(p), 32'h4000);

    // R2: busy after accepting edge
    @(negedge clk);
    a8 = 8'h05; b8 = 8'h06; start8 = 1'b1;
    @(posedge clk); @(negedge clk);
    start8 = 1'b0;
    check("R2 busy after start", 32'(busy8), 1);
    // R8: operands change while busy
    a8 = 8'hF0; b8 = 8'h11;
    // R6: start while busy
    repeat (2) @(negedge clk);
    start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 3;
    while (!done8 && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R6 latency unchanged by extra start", lat, W);
    check("R8 product uses captured operands", 32'(p8), 32'h001E);

    // R7: hold after done
    p = p8;
    a8 = 8'h33; b8 = 8'h44;
    repeat (6) @(negedge clk);
    check("R7 product held", 32'(p8), 32'(p));
    check("R7 no stray done", 32'(done8), 0);

    // R4 with 4-bit operands
    run4(4'b0010, 4'b0111, q);
    check("R4 w4 2x7", 32'(q), 32'h0E);
    run4(4'b0010, 4'b1101, q);
    check("R4 w4 2x-3", 32'(q), 32'hFA);
    run4(4'b1000, 4'b1000, q);
    check("R5 w4 -8x-8", 32'(q), 32'h40);
    run4(4'b1000, 4'b0111, q);
    check("R5 w4 -8x7", 32'(q), 32'hC8);

    // R1: reset mid-operation
    @(negedge clk);
    a8 = 8'h12; b8 = 8'h34; start8 = 1'b1;
    @(posedge clk); @(negedge clk);
    start8 = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 busy cleared by reset", 32'(busy8), 0);
    check("R1 product cleared by reset", 32'(p8), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run8(8'hFE, 8'h07, p, lat);
    check("R4 after reset -2x7", 32'(p), 32'hFFF2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule